// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Cell

This block is a synthesizable behavioural model of a configurable logic cell. It has eight data inputs and a 64-bit truth mask. A small control word splits the mask in one of several ways. The cell can evaluate one six-input function that steers its result to either the upper or the lower output path. It can also evaluate two smaller functions at the same time, which must share inputs according to fixed packing rules. Pairs smaller than the mode sizes (4+3, 3+3, 3+2, 5+2) are obtained by giving the unused inputs don't-care entries in the mask.

Each output path has a combinational output and a selectable output. The selectable output shows either the combinational value or a flip-flop. Each flip-flop has its own enable and synchronous clear. When a single six-input function occupies only one input pair, the idle pair can feed a flip-flop directly; this is register packing. The mask and the control word are written through a parallel configuration port. A write takes effect from the next clock edge.

Top module: `fl6_cell`

## Requirements
- R1: After reset, the mask, the control word and both flip-flops are 0. The cell is then in mode 0 with both bypasses clear, so comb0, comb1, out0 and out1 all read 0.
- R2: A write with cfg_we=1 stores the whole cfg_data in the mask when cfg_addr=0, or stores cfg_data[6:0] in the control word when cfg_addr=1. The new value shows on the outputs only after the clock edge that captures it. Control word fields: mode [2:0], bypass0 [3], bypass1 [4], pack0 [5], pack1 [6].
- R3: Mode 0 (upper single): comb0 = mask[{f0,e0,d,c,b,a}] (a is the LSB of the index) and comb1 = 0.
- R4: Mode 1 (lower single): comb1 = mask[{f1,e1,d,c,b,a}] and comb0 = 0.
- R5: Mode 2 (5+5, sharing a and b): comb0 = mask[{f0,e0,c,b,a}] and comb1 = mask[32 + {f1,e1,d,b,a}].
- R6: Mode 3 (5+4, sharing a): comb0 = mask[{f0,e0,c,b,a}] and comb1 = mask[32 + {f1,e1,d,a}].
- R7: Mode 4 (4+4, no shared input): comb0 = mask[{f0,e0,b,a}] and comb1 = mask[16 + {f1,e1,d,c}].
- R8: Mode 5 (6+6 with one shared function): comb0 = mask[{f0,e0,d,c,b,a}] and comb1 = mask[{f1,e1,d,c,b,a}]. Modes 6 and 7 drive comb0 = comb1 = 0.
- R9: When bypass i is set, out i equals comb i in the same cycle. When it is clear, out i shows flip-flop i.
- R10: On each clock edge, flip-flop i is cleared if reg_sclr[i]=1, whatever reg_en[i] is. Otherwise it loads its data input if reg_en[i]=1, and otherwise it holds its value.
- R11: In mode 1 with pack0 set, flip-flop 0 loads in_e0 instead of comb0.
- R12: In mode 0 with pack1 set, flip-flop 1 loads in_f1 only while bypass0 is set. While bypass0 is clear, pack1 is ignored and flip-flop 1 loads comb1 (which is 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the mask, 1 selects the control word |
| cfg_data | input | 64 | Configuration write data |
| in_a | input | 1 | Data input a |
| in_b | input | 1 | Data input b |
| in_c | input | 1 | Data input c |
| in_d | input | 1 | Data input d |
| in_e0 | input | 1 | Data input e0 (upper pair) |
| in_f0 | input | 1 | Data input f0 (upper pair) |
| in_e1 | input | 1 | Data input e1 (lower pair) |
| in_f1 | input | 1 | Data input f1 (lower pair) |
| reg_en | input | 2 | Per-flip-flop clock enable |
| reg_sclr | input | 2 | Per-flip-flop synchronous clear |
| comb0 | output | 1 | Upper combinational result |
| comb1 | output | 1 | Lower combinational result |
| out0 | output | 1 | Upper selectable output |
| out1 | output | 1 | Lower selectable output |

## Verification
The hardest case to reach is lower register packing. Flip-flop 1 takes in_f1 only when three things hold together: the cell is in the upper single mode, pack1 is set and bypass0 is set. To get there, the stimulus writes the control word with bypass1 clear, so that out1 shows the flip-flop. It then toggles in_f1 under the enable and compares out1 with in_f1. It then clears bypass0 alone and shows that the flip-flop falls back to the always-zero lower result. Every mode is swept over all 256 input patterns with two different masks, and both bypasses are set during the sweep so that the selectable outputs are checked as well.

// File: rtl/fl6_pkg.sv
package fl6_pkg;
    localparam int LUT_K  = 6;
    localparam int MASK_W = 1 << LUT_K;
    localparam int NPATH  = 2;
    localparam int IN_W   = 8;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_TOP6 = 3'd0,
        M_BOT6 = 3'd1,
        M_5_5  = 3'd2,
        M_5_4  = 3'd3,
        M_4_4  = 3'd4,
        M_6_6  = 3'd5
    } mode_e;

    typedef struct packed {
        logic              pack1;
        logic              pack0;
        logic [NPATH-1:0]  byp;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic lut_pick(input logic [MASK_W-1:0] m,
                                      input logic [LUT_K-1:0]  idx);
        return m[idx];
    endfunction
endpackage

// File: rtl/fl6_cfg_store.sv
module fl6_cfg_store
    import fl6_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [MASK_W-1:0] cfg_data,
    output logic [MASK_W-1:0] mask,
    output ctrl_t             ctrl
);
    typedef struct packed {
        logic [MASK_W-1:0] mask;
        ctrl_t             ctrl;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            if (cfg_addr) st_d.ctrl = ctrl_t'(cfg_data[CTRL_W-1:0]);
            else          st_d.mask = cfg_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.mask;
    assign ctrl = st_q.ctrl;
endmodule

// File: rtl/fl6_lut_split.sv
module fl6_lut_split
    import fl6_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    input  logic [MODE_W-1:0] mode,
    input  logic [IN_W-1:0]   din,   // {f1,e1,f0,e0,d,c,b,a}
    output logic [NPATH-1:0]  comb
);
    logic [LUT_K-1:0] idx_top6, idx_bot6;
    logic [LUT_K-1:0] idx_top5, idx_bot5, idx_bot4s, idx_top4, idx_bot4;

    always_comb begin
        idx_top6  = din[5:0];
        idx_bot6  = {din[7:6], din[3:0]};
        idx_top5  = {1'b0, din[5:4], din[2:0]};
        idx_bot5  = {1'b1, din[7:6], din[3], din[1:0]};
        idx_bot4s = {2'b10, din[7:6], din[3], din[0]};
        idx_top4  = {2'b00, din[5:4], din[1:0]};
        idx_bot4  = {2'b01, din[7:6], din[3:2]};
    end

    always_comb begin
        comb = '0;
        case (mode)
            M_TOP6: comb[0] = lut_pick(mask, idx_top6);
            M_BOT6: comb[1] = lut_pick(mask, idx_bot6);
            M_5_5: begin
                comb[0] = lut_pick(mask, idx_top5);
                comb[1] = lut_pick(mask, idx_bot5);
            end
            M_5_4: begin
                comb[0] = lut_pick(mask, idx_top5);
                comb[1] = lut_pick(mask, idx_bot4s);
            end
            M_4_4: begin
                comb[0] = lut_pick(mask, idx_top4);
                comb[1] = lut_pick(mask, idx_bot4);
            end
            M_6_6: begin
                comb[0] = lut_pick(mask, idx_top6);
                comb[1] = lut_pick(mask, idx_bot6);
            end
            default: comb = '0;
        endcase
    end
endmodule

// File: rtl/fl6_out_reg.sv
module fl6_out_reg
    import fl6_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPATH-1:0] dat,
    input  logic [NPATH-1:0] en,
    input  logic [NPATH-1:0] sclr,
    output logic [NPATH-1:0] q
);
    typedef struct packed {
        logic [NPATH-1:0] r;
    } reg_st_t;

    reg_st_t st_d, st_q;

    for (genvar i = 0; i < NPATH; i++) begin : g_path
        always_comb begin
            if (sclr[i])    st_d.r[i] = 1'b0;
            else if (en[i]) st_d.r[i] = dat[i];
            else            st_d.r[i] = st_q.r[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.r;
endmodule

// File: rtl/fl6_cell.sv
module fl6_cell
    import fl6_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [MASK_W-1:0] cfg_data,
    input  logic              in_a,
    input  logic              in_b,
    input  logic              in_c,
    input  logic              in_d,
    input  logic              in_e0,
    input  logic              in_f0,
    input  logic              in_e1,
    input  logic              in_f1,
    input  logic [NPATH-1:0]  reg_en,
    input  logic [NPATH-1:0]  reg_sclr,
    output logic              comb0,
    output logic              comb1,
    output logic              out0,
    output logic              out1
);
    logic [MASK_W-1:0] cfg_mask;
    ctrl_t             cfg_ctrl;
    logic [IN_W-1:0]   din;
    logic [NPATH-1:0]  comb;
    logic [NPATH-1:0]  reg_din;
    logic [NPATH-1:0]  reg_q;

    assign din = {in_f1, in_e1, in_f0, in_e0, in_d, in_c, in_b, in_a};

    fl6_cfg_store u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .mask     (cfg_mask),
        .ctrl     (cfg_ctrl)
    );

    fl6_lut_split u_lut (
        .mask (cfg_mask),
        .mode (cfg_ctrl.mode),
        .din  (din),
        .comb (comb)
    );

    // Register packing: an idle input pair feeds a flip-flop directly.
    always_comb begin
        reg_din = comb;
        if (cfg_ctrl.mode == M_BOT6 && cfg_ctrl.pack0)
            reg_din[0] = in_e0;
        if (cfg_ctrl.mode == M_TOP6 && cfg_ctrl.pack1 && cfg_ctrl.byp[0])
            reg_din[1] = in_f1;
    end

    fl6_out_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .dat   (reg_din),
        .en    (reg_en),
        .sclr  (reg_sclr),
        .q     (reg_q)
    );

    assign comb0 = comb[0];
    assign comb1 = comb[1];
    assign out0  = cfg_ctrl.byp[0] ? comb[0] : reg_q[0];
    assign out1  = cfg_ctrl.byp[1] ? comb[1] : reg_q[1];
endmodule

// File: rtl/fl6_cell_chk.sv
module fl6_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       cfg_addr,
    input logic [2:0] cfg_mode_wr,
    input logic [2:0] mode,
    input logic       byp0,
    input logic       pack1,
    input logic       in_e0,
    input logic       in_f0,
    input logic       in_e1,
    input logic       in_f1,
    input logic       in_f1_dup,
    input logic [1:0] reg_en,
    input logic [1:0] reg_sclr,
    input logic [1:0] reg_din,
    input logic [1:0] reg_q,
    input logic       comb0,
    input logic       comb1
);
    // R2
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr) |=> (mode == $past(cfg_mode_wr)));

    // R3
    top_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0) |-> (comb1 == 1'b0));

    // R4
    bot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |-> (comb0 == 1'b0));

    // R8
    shared_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && in_e0 == in_e1 && in_f0 == in_f1) |-> (comb0 == comb1));

    // R10
    sclr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sclr[0] |=> (reg_q[0] == 1'b0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sclr[1] && !reg_en[1]) |=> $stable(reg_q[1]));

    // R10
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en[0] && !reg_sclr[0]) |=> (reg_q[0] == $past(reg_din[0])));

    // R12
    pack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && pack1 && byp0 && reg_en[1] && !reg_sclr[1])
        |=> (reg_q[1] == $past(in_f1_dup)));
endmodule

bind fl6_cell fl6_cell_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_mode_wr (cfg_data[2:0]),
    .mode        (cfg_ctrl.mode),
    .byp0        (cfg_ctrl.byp[0]),
    .pack1       (cfg_ctrl.pack1),
    .in_e0       (in_e0),
    .in_f0       (in_f0),
    .in_e1       (in_e1),
    .in_f1       (in_f1),
    .in_f1_dup   (in_f1),
    .reg_en      (reg_en),
    .reg_sclr    (reg_sclr),
    .reg_din     (reg_din),
    .reg_q       (reg_q),
    .comb0       (comb0),
    .comb1       (comb1)
);

// File: tb/fl6_cell_tb_top.sv
`timescale 1ns/1ps
module fl6_cell_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [63:0] cfg_data = '0;
    logic [7:0]  vin = '0;          // {f1,e1,f0,e0,d,c,b,a}
    logic [1:0]  reg_en = '0;
    logic [1:0]  reg_sclr = '0;
    logic        comb0, comb1, out0, out1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fl6_cell dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .in_a(vin[0]), .in_b(vin[1]), .in_c(vin[2]), .in_d(vin[3]),
        .in_e0(vin[4]), .in_f0(vin[5]), .in_e1(vin[6]), .in_f1(vin[7]),
        .reg_en(reg_en), .reg_sclr(reg_sclr),
        .comb0(comb0), .comb1(comb1), .out0(out0), .out1(out1)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Expected results computed arithmetically from the requirement formulas
    function automatic logic [1:0] model(input int mode, input logic [63:0] m,
                                         input logic [7:0] v);
        int a = v[0], b = v[1], c = v[2], d = v[3];
        int e0 = v[4], f0 = v[5], e1 = v[6], f1 = v[7];
        int top6 = a + 2*b + 4*c + 8*d + 16*e0 + 32*f0;
        int bot6 = a + 2*b + 4*c + 8*d + 16*e1 + 32*f1;
        logic [1:0] r = 2'b00;
        case (mode)
            0: r[0] = m[top6];
            1: r[1] = m[bot6];
            2: begin r[0] = m[a + 2*b + 4*c + 8*e0 + 16*f0];
                     r[1] = m[32 + a + 2*b + 4*d + 8*e1 + 16*f1]; end
            3: begin r[0] = m[a + 2*b + 4*c + 8*e0 + 16*f0];
                     r[1] = m[32 + a + 2*d + 4*e1 + 8*f1]; end
            4: begin r[0] = m[a + 2*b + 4*e0 + 8*f0];
                     r[1] = m[16 + c + 2*d + 4*e1 + 8*f1]; end
            5: begin r[0] = m[top6]; r[1] = m[bot6]; end
            default: r = 2'b00;
        endcase
        return r;
    endfunction

    task automatic cfg_write(input logic addr, input logic [63:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [63:0] ctrl_word(input int mode, input logic byp0,
        input logic byp1, input logic pk0, input logic pk1);
        return {57'd0, pk1, pk0, byp1, byp0, mode[2:0]};
    endfunction

    task automatic clock_reg(input logic [1:0] en, input logic [1:0] sc);
        @(negedge clk);
        reg_en = en; reg_sclr = sc;
        @(negedge clk);
        reg_en = '0; reg_sclr = '0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] masks [2];
        logic [1:0]  e;
        masks[0] = 64'hA5C3_96E1_0F3C_7B28;
        masks[1] = 64'h1E87_D24B_6C39_F05A;

        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(comb0, 1'b0, "R1 comb0");
        check(comb1, 1'b0, "R1 comb1");
        check(out0,  1'b0, "R1 out0");
        check(out1,  1'b0, "R1 out1");
        rst_n = 1'b1;

        // R2: mask write visible only after its capturing edge
        vin = 8'h00;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 1'b0; cfg_data = '1;
        #2;
        check(comb0, 1'b0, "R2 before edge");
        @(negedge clk);
        cfg_we = 1'b0;
        #2;
        check(comb0, 1'b1, "R2 after edge");

        // R3..R9: exhaustive sweep, bypass set so outputs follow comb
        for (int md = 0; md < 8; md++) begin
            for (int mi = 0; mi < 2; mi++) begin
                cfg_write(1'b0, masks[mi]);
                cfg_write(1'b1, ctrl_word(md, 1'b1, 1'b1, 1'b0, 1'b0));
                for (int v = 0; v < 256; v++) begin
                    @(negedge clk);
                    vin = v[7:0];
                    #2;
                    e = model(md, masks[mi], vin);
                    case (md)
                        0: begin check(comb0, e[0], "R3 comb0"); check(comb1, e[1], "R3 comb1"); end
                        1: begin check(comb0, e[0], "R4 comb0"); check(comb1, e[1], "R4 comb1"); end
                        2: begin check(comb0, e[0], "R5 comb0"); check(comb1, e[1], "R5 comb1"); end
                        3: begin check(comb0, e[0], "R6 comb0"); check(comb1, e[1], "R6 comb1"); end
                        4: begin check(comb0, e[0], "R7 comb0"); check(comb1, e[1], "R7 comb1"); end
                        default: begin check(comb0, e[0], "R8 comb0"); check(comb1, e[1], "R8 comb1"); end
                    endcase
                    check(out0, e[0], "R9 out0 bypass");
                    check(out1, e[1], "R9 out1 bypass");
                end
            end
        end

        // R10: load, hold, clear priority (mode 0, all-ones mask, no bypass)
        cfg_write(1'b0, '1);
        cfg_write(1'b1, ctrl_word(0, 1'b0, 1'b0, 1'b0, 1'b0));
        vin = 8'h00;
        #1;
        check(out0, 1'b0, "R9 out0 shows flip-flop");
        clock_reg(2'b01, 2'b00);
        check(out0, 1'b1, "R10 load");
        cfg_write(1'b0, '0);
        #1;
        check(comb0, 1'b0, "R10 comb now 0");
        check(out0, 1'b1, "R10 hold");
        cfg_write(1'b0, '1);
        clock_reg(2'b01, 2'b01);
        check(out0, 1'b0, "R10 clear beats enable");
        clock_reg(2'b01, 2'b00);
        check(out0, 1'b1, "R10 reload");
        clock_reg(2'b00, 2'b01);
        check(out0, 1'b0, "R10 clear without enable");

        // R11: pack e0 into flip-flop 0 in mode 1
        cfg_write(1'b1, ctrl_word(1, 1'b0, 1'b0, 1'b1, 1'b0));
        vin = 8'h10;
        clock_reg(2'b01, 2'b00);
        check(out0, 1'b1, "R11 packed e0=1");
        vin = 8'h00;
        clock_reg(2'b01, 2'b00);
        check(out0, 1'b0, "R11 packed e0=0");

        // R12: pack f1 into flip-flop 1 in mode 0 with bypass0 set
        cfg_write(1'b1, ctrl_word(0, 1'b1, 1'b0, 1'b0, 1'b1));
        vin = 8'h80;
        clock_reg(2'b10, 2'b00);
        check(out1, 1'b1, "R12 packed f1=1");
        vin = 8'h00;
        clock_reg(2'b10, 2'b00);
        check(out1, 1'b0, "R12 packed f1=0");
        vin = 8'h80;
        clock_reg(2'b10, 2'b00);
        check(out1, 1'b1, "R12 packed f1=1 again");
        cfg_write(1'b1, ctrl_word(0, 1'b0, 1'b0, 1'b0, 1'b1));
        clock_reg(2'b10, 2'b00);
        check(out1, 1'b0, "R12 pack ignored without bypass0");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule